// File: doc/BRIEF.md
# Dual-Buffer Audio DMA Address Engine

This block produces memory addresses for one audio stream channel. Software programs two memory regions. Each region has its own 32-bit base address and its own 16-bit length. Software also programs a sample format and then sets a resume bit. Each sample request strobe consumes the address on `mem_addr_o` and then advances an offset by the byte size of one sample frame.

When the offset reaches the length of the active region, the engine does three things: it raises that region's finished flag, returns the offset to zero and continues at the other region's base. The two regions therefore alternate in a ping-pong pattern. Software refills the region that has just finished while the other region plays. A finished flag stays set until software writes a 1 to its bit. The interrupt output is high while either flag is set.

The register bus is 16 bits wide and uses byte offsets. Reads are combinational from `reg_addr_i`. Writes take effect at the clock edge on which `reg_we_i` is high.

Top module: `pingpong_dma_addr`

## Requirements
- R1: After reset, reading the control word (0x00) gives 0x0000, the finished-flag word (0x02) gives 0x0000, the format word (0x16) gives 0x0010, and the position (0x10 low half, 0x12 high half) and offset (0x14) read 0. `irq_o` is low.
- R2: The region 1 base is written and read as two halves: the low half at 0x04 and the high half at 0x06. The region 2 base uses 0x08 (low) and 0x0a (high). The region 1 length is at 0x0c and the region 2 length is at 0x0e. Each of these reads back exactly what was written.
- R3: The control word and the format word keep only bits 5..0. Bits 15..6 of both always read as zero, whatever value was written.
- R4: Each accepted request adds a step to the offset. The step is 1 byte for 8-bit mono, 2 bytes when exactly one of format bit 4 (16-bit samples) or format bit 5 (two channels) is set, and 4 bytes when both are set.
- R5: A request is accepted only while control bit 0 (resume) is set. While resume is clear, requests leave the offset, the position and the active region unchanged. Setting resume again continues from the frozen point.
- R6: The position (0x10/0x12) and `mem_addr_o` both equal the active region's base plus the offset.
- R7: An accepted request whose new offset would be equal to or greater than the active region's length completes that region. The offset returns to 0, the other region becomes active, and a finished flag is set: bit 1 of 0x02 for region 1, or bit 2 of 0x02 for region 2.
- R8: Writing 0x02 clears each finished flag whose bit is 1 in the written data. Flags whose bits are 0 are not changed. Writing 0xffff clears both flags.
- R9: `irq_o` is high exactly while at least one finished flag is set.
- R10: If a region completes in the same cycle as a write that clears its flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| sample_req_i | input | 1 | One sample frame consumed at `mem_addr_o` |
| mem_addr_o | output | 32 | Current memory address |
| irq_o | output | 1 | High while any finished flag is set |

## Verification
The assertions assume that software does not change a region's length or the format while requests are being accepted. Under that assumption, every offset change is either one step of 1, 2 or 4 bytes or a wrap to zero. They also assume that `sample_req_i` is a clean strobe that is sampled at the clock edge. The stimulus keeps to these assumptions in three ways: it reprograms length and format only between request pulses, it drives every input on the falling clock edge, and it gives each pulse exactly one cycle.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam int RA_W = 5;

  localparam logic [RA_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [RA_W-1:0] OFS_FIN    = 5'h02;
  localparam logic [RA_W-1:0] OFS_BASE1L = 5'h04;
  localparam logic [RA_W-1:0] OFS_LEN1   = 5'h0c;
  localparam logic [RA_W-1:0] OFS_LEN2   = 5'h0e;
  localparam logic [RA_W-1:0] OFS_POSL   = 5'h10;
  localparam logic [RA_W-1:0] OFS_POSH   = 5'h12;
  localparam logic [RA_W-1:0] OFS_OFFS   = 5'h14;
  localparam logic [RA_W-1:0] OFS_FMT    = 5'h16;

  typedef struct packed {
    logic       two_ch;
    logic       wide;
    logic [3:0] rate;
  } fmt_t;

  localparam fmt_t FMT_RST = '{two_ch: 1'b0, wide: 1'b1, rate: 4'h0};
endpackage

// File: rtl/ppdma_regs.sv
module ppdma_regs
  import ppdma_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [RA_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [1:0]                 fin_set_i,
  input  logic [DATA_W-1:0]          ofs_i,
  input  logic [ADDR_W-1:0]          pos_i,
  output logic [1:0][ADDR_W-1:0]     base_o,
  output logic [1:0][DATA_W-1:0]     len_o,
  output logic                       run_o,
  output fmt_t                       fmt_o,
  output logic [1:0]                 fin_o
);
  logic [5:0] ctrl_q;
  fmt_t       fmt_q;
  logic [1:0] fin_q, fin_clr;

  for (genvar g = 0; g < 2; g++) begin : g_region
    localparam logic [RA_W-1:0] LO_OFS  = OFS_BASE1L + RA_W'(4 * g);
    localparam logic [RA_W-1:0] HI_OFS  = LO_OFS + RA_W'(2);
    localparam logic [RA_W-1:0] LEN_OFS = OFS_LEN1 + RA_W'(2 * g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        len_o[g]  <= '0;
      end else if (we_i) begin
        if (addr_i == LO_OFS)  base_o[g][DATA_W-1:0]      <= wdata_i;
        if (addr_i == HI_OFS)  base_o[g][ADDR_W-1:DATA_W] <= wdata_i;
        if (addr_i == LEN_OFS) len_o[g]                   <= wdata_i;
      end
    end
  end

  // bit 1 -> region 1, bit 2 -> region 2
  assign fin_clr = (we_i && addr_i == OFS_FIN) ? wdata_i[2:1] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      fmt_q  <= FMT_RST;
      fin_q  <= '0;
    end else begin
      if (we_i && addr_i == OFS_CTRL) ctrl_q <= wdata_i[5:0];
      if (we_i && addr_i == OFS_FMT)  fmt_q  <= fmt_t'(wdata_i[5:0]);
      fin_q <= (fin_q & ~fin_clr) | fin_set_i;  // set wins
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL:        rdata_o = DATA_W'(ctrl_q);
      OFS_FIN:         rdata_o = DATA_W'({fin_q, 1'b0});
      5'h04:           rdata_o = base_o[0][DATA_W-1:0];
      5'h06:           rdata_o = base_o[0][ADDR_W-1:DATA_W];
      5'h08:           rdata_o = base_o[1][DATA_W-1:0];
      5'h0a:           rdata_o = base_o[1][ADDR_W-1:DATA_W];
      OFS_LEN1:        rdata_o = len_o[0];
      OFS_LEN2:        rdata_o = len_o[1];
      OFS_POSL:        rdata_o = pos_i[DATA_W-1:0];
      OFS_POSH:        rdata_o = pos_i[ADDR_W-1:DATA_W];
      OFS_OFFS:        rdata_o = ofs_i;
      OFS_FMT:         rdata_o = DATA_W'(fmt_q);
      default:         rdata_o = '0;
    endcase
  end

  assign run_o = ctrl_q[0];
  assign fmt_o = fmt_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/ppdma_seq.sv
module ppdma_seq #(
  parameter int LEN_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   req_i,
  input  logic                   wide_i,
  input  logic                   two_ch_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic [1:0][LEN_W-1:0]  len_i,
  output logic [LEN_W-1:0]       ofs_o,
  output logic                   region_o,
  output logic [1:0]             fin_set_o,
  output logic [ADDR_W-1:0]      pos_o
);
  logic [LEN_W-1:0] ofs_q;
  logic             region_q;
  logic [LEN_W:0]   step, nxt;
  logic             adv, wrap;

  assign step = (LEN_W+1)'(1) << ({1'b0, wide_i} + {1'b0, two_ch_i});
  assign nxt  = {1'b0, ofs_q} + step;
  assign wrap = nxt >= {1'b0, len_i[region_q]};
  assign adv  = run_i & req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q    <= '0;
      region_q <= 1'b0;
    end else if (adv) begin
      if (wrap) begin
        ofs_q    <= '0;
        region_q <= ~region_q;
      end else begin
        ofs_q    <= nxt[LEN_W-1:0];
      end
    end
  end

  assign fin_set_o = (adv && wrap) ? (region_q ? 2'b10 : 2'b01) : 2'b00;
  assign pos_o     = base_i[region_q] + ADDR_W'(ofs_q);
  assign ofs_o     = ofs_q;
  assign region_o  = region_q;
endmodule

// File: rtl/pingpong_dma_addr.sv
module pingpong_dma_addr
  import ppdma_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sample_req_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              irq_o
);
  logic [1:0][ADDR_W-1:0] base;
  logic [1:0][DATA_W-1:0] len;
  logic                   run;
  fmt_t                   fmt;
  logic [1:0]             fin, fin_set;
  logic [DATA_W-1:0]      ofs_q;
  logic                   region_q;
  logic [ADDR_W-1:0]      pos;

  ppdma_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .fin_set_i(fin_set), .ofs_i(ofs_q), .pos_i(pos),
    .base_o(base), .len_o(len), .run_o(run), .fmt_o(fmt), .fin_o(fin)
  );

  ppdma_seq #(.LEN_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .run_i(run), .req_i(sample_req_i), .wide_i(fmt.wide), .two_ch_i(fmt.two_ch),
    .base_i(base), .len_i(len), .ofs_o(ofs_q), .region_o(region_q),
    .fin_set_o(fin_set), .pos_o(pos)
  );

  assign mem_addr_o = pos;
  assign irq_o      = |fin;
endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              sample_req_i,
  input logic              run,
  input logic [DATA_W-1:0] ofs_q,
  input logic              region_q,
  input logic [1:0]        fin,
  input logic              irq_o
);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 5'h00 || reg_addr_i == 5'h16) |-> reg_rdata_o[DATA_W-1:6] == '0);

  a_r4_step_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sample_req_i) |=> (ofs_q == '0) ||
      (($countones(DATA_W'(ofs_q - $past(ofs_q))) == 1) &&
       (DATA_W'(ofs_q - $past(ofs_q)) <= DATA_W'(4))));

  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run && sample_req_i) |=> $stable(ofs_q) && $stable(region_q));

  a_r7_switch_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(region_q) |-> (region_q ? fin[0] : fin[1]));

  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(run && sample_req_i));
endmodule

bind pingpong_dma_addr ppdma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_rdata_o, .sample_req_i,
  .run, .ofs_q, .region_q, .fin, .irq_o
);

// File: tb/pingpong_dma_addr_test.sv
module pingpong_dma_addr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req = 1'b0;
  logic [31:0] maddr;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_dma_addr uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sample_req_i(req),
    .mem_addr_o(maddr), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic chk_rd(string tag, logic [4:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(tag, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic chk_pos(string tag, logic [31:0] exp);
    logic [15:0] lo, hi;
    rd(5'h10, lo);
    rd(5'h12, hi);
    check(tag, {hi, lo}, exp);
    check({tag, " mem_addr_o"}, maddr, exp);
  endtask

  task automatic t_reset();
    chk_rd("R1 ctrl", 5'h00, 16'h0000);
    chk_rd("R1 flags", 5'h02, 16'h0000);
    chk_rd("R1 format", 5'h16, 16'h0010);
    chk_rd("R1 offset", 5'h14, 16'h0000);
    chk_pos("R1 position", 32'h0);
    check("R1 irq_o", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    wr(5'h04, 16'h0100); wr(5'h06, 16'h1000);
    wr(5'h08, 16'h0200); wr(5'h0a, 16'h2000);
    wr(5'h0c, 16'd8);    wr(5'h0e, 16'd6);
    chk_rd("R2 base1 lo", 5'h04, 16'h0100);
    chk_rd("R2 base1 hi", 5'h06, 16'h1000);
    chk_rd("R2 base2 lo", 5'h08, 16'h0200);
    chk_rd("R2 base2 hi", 5'h0a, 16'h2000);
    chk_rd("R2 len1", 5'h0c, 16'd8);
    chk_rd("R2 len2", 5'h0e, 16'd6);
    wr(5'h00, 16'hffff);
    chk_rd("R3 ctrl upper bits", 5'h00, 16'h003f);
    wr(5'h00, 16'h0000);
    wr(5'h16, 16'hffff);
    chk_rd("R3 format upper bits", 5'h16, 16'h003f);
    wr(5'h16, 16'h0000);
  endtask

  task automatic t_freeze_start();
    pulse();
    chk_rd("R5 offset frozen at start", 5'h14, 16'd0);
    chk_pos("R6 position at base1", 32'h1000_0100);
  endtask

  task automatic t_steps();
    wr(5'h00, 16'h0001);
    pulse();
    chk_rd("R4 step 1 byte", 5'h14, 16'd1);
    chk_pos("R6 position base1+1", 32'h1000_0101);
    wr(5'h16, 16'h0010);
    pulse();
    chk_rd("R4 step 2 bytes", 5'h14, 16'd3);
    wr(5'h16, 16'h0030);
    pulse();
    chk_rd("R4 step 4 bytes", 5'h14, 16'd7);
    wr(5'h00, 16'h0000);
    pulse();
    chk_rd("R5 paused offset", 5'h14, 16'd7);
    chk_pos("R5 paused position", 32'h1000_0107);
    wr(5'h00, 16'h0001);
    wr(5'h16, 16'h0000);
    pulse();
    chk_rd("R7 offset wraps", 5'h14, 16'd0);
    chk_pos("R7 switched to base2", 32'h2000_0200);
    chk_rd("R7 region1 flag", 5'h02, 16'h0002);
    check("R9 irq_o set", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    wr(5'h02, 16'h0004);
    chk_rd("R8 clear of unset flag", 5'h02, 16'h0002);
    wr(5'h02, 16'h0000);
    chk_rd("R8 zero write no effect", 5'h02, 16'h0002);
    wr(5'h02, 16'h0002);
    chk_rd("R8 flag cleared", 5'h02, 16'h0000);
    check("R9 irq_o cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_region2();
    wr(5'h16, 16'h0030);
    pulse();
    chk_pos("R6 position base2+4", 32'h2000_0204);
    pulse();
    chk_rd("R7 region2 flag", 5'h02, 16'h0004);
    chk_pos("R7 back at base1", 32'h1000_0100);
    check("R9 irq_o from region2", {31'h0, irq}, 32'h1);
    wr(5'h02, 16'hffff);
    chk_rd("R8 global clear", 5'h02, 16'h0000);
  endtask

  task automatic t_collide();
    pulse();
    @(negedge clk);
    we = 1'b1; addr = 5'h02; wdata = 16'hffff; req = 1'b1;
    @(negedge clk);
    we = 1'b0; req = 1'b0;
    chk_rd("R10 set wins over clear", 5'h02, 16'h0002);
    check("R10 irq_o stays", {31'h0, irq}, 32'h1);
    chk_pos("R10 switched to base2", 32'h2000_0200);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_freeze_start();
    t_steps();
    t_w1c();
    t_region2();
    t_collide();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule